// File: doc/BRIEF.md
# Status Register Stack-Pull Sequencer

This block carries out the one-byte instruction that restores the processor status register from the stack, for a core with an 8-bit emulation mode and a 16-bit native mode. When the core presents opcode 0x28 with a start strobe, the block first steps the stack pointer. It then reads the byte at the new stack address through a synchronous read port and writes that byte into the status register. The mode decides how bits 5 and 4 are stored. The instruction always takes four clock cycles.

The block holds the stack pointer, the status register and the emulation flag. The rest of the core can overwrite each of them through a write port when no pull is using it. In native mode, a pull that leaves the index-width flag set raises a one-cycle pulse. An index-width controller outside the block uses this pulse to clear the high bytes of the index registers.

Top module: `stat_pull_seq`

## Requirements
- R1: While rst_n is low, and after it is released, done_o, busy_o, mem_rd_en_o and xh_clr_o are 0, sp_o is 0x01FF, p_o is 0x34 and e_o is 1.
- R2: A pull starts only when start_i is high, opcode_i equals 0x28 and the block is idle. A strobe with any other opcode, or a strobe that arrives while busy_o is high, is ignored.
- R3: If start_i is accepted in cycle 1, busy_o is high in cycles 2 to 4, mem_rd_en_o is high in cycle 3 only, and done_o is high in cycle 4 only.
- R4: The read address in cycle 3 is the stack pointer after the increment. From cycle 4 on, sp_o shows that incremented value.
- R5: In emulation mode (e_o = 1), the upper byte of the stack pointer and of the read address is 0x01. The lower byte increments and wraps from 0xFF to 0x00.
- R6: In native mode (e_o = 0), the full 16-bit stack pointer increments and wraps from 0xFFFF to 0x0000.
- R7: In native mode, from cycle 5 p_o equals the byte read. Bit 7 is N, bit 6 V, bit 5 M (accumulator width), bit 4 X (index width), bit 3 D, bit 2 I, bit 1 Z and bit 0 C.
- R8: In emulation mode, bits 7, 6 and 3..0 of p_o take the byte read, bit 4 (B) takes bit 4 of the byte, and bit 5 of p_o always reads 1.
- R9: The pull never changes e_o. Only e_wr_en_i changes it, one cycle after the write.
- R10: xh_clr_o is high in cycle 4 exactly when the mode is native and bit 4 of the byte read is 1. Otherwise it is low.
- R11: An sp_wr_en_i in cycle 3 of a pull, or a p_wr_en_i in cycle 4, is ignored and the pull's result stands. At any other time each write shows on sp_o or p_o from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Instruction strobe, opcode fetch cycle |
| opcode_i | input | 8 | Fetched opcode |
| sp_wr_en_i | input | 1 | Stack pointer write enable |
| sp_wr_data_i | input | 16 | Stack pointer write value |
| p_wr_en_i | input | 1 | Status register write enable |
| p_wr_data_i | input | 8 | Status register write value |
| e_wr_en_i | input | 1 | Emulation flag write enable |
| e_wr_data_i | input | 1 | Emulation flag write value |
| mem_rd_en_o | output | 1 | Stack read request |
| mem_addr_o | output | 16 | Stack read address |
| mem_rd_data_i | input | 8 | Read data, valid the cycle after the request |
| sp_o | output | 16 | Stack pointer as seen by the core |
| p_o | output | 8 | Status register as seen by the core |
| e_o | output | 1 | Emulation flag |
| busy_o | output | 1 | Pull in progress after the fetch cycle |
| done_o | output | 1 | Final cycle of the pull |
| xh_clr_o | output | 1 | Index high-byte clear pulse |

## Verification
Two things can happen in the same cycle: the sequencer's own update of a register and an outside write to that same register. The stack pointer can collide in cycle 3 and the status register in cycle 4. The bench asserts sp_wr_en_i or p_wr_en_i in exactly those cycles, picked at random and also in directed cases. It then checks that sp_o and p_o hold the values the pull computed and not the written values. Writes made while the block is idle are checked to land, which shows the port itself works.

// File: rtl/stat_pull_pkg.sv
package stat_pull_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INTL  = 2'd1,
    ST_STACK = 2'd2,
    ST_LOAD  = 2'd3
  } seq_state_e;

  localparam logic [7:0] OPC_PULL_STATUS = 8'h28;
  localparam int         FLAG_BIT_UNUSED = 5;
  localparam int         FLAG_BIT_INDEX  = 4;

endpackage

// File: rtl/stat_pull_fsm.sv
module stat_pull_fsm
  import stat_pull_pkg::*;
#(
  parameter int         OPC_W  = 8,
  parameter logic [7:0] OPCODE = OPC_PULL_STATUS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [OPC_W-1:0] opcode_i,
  output logic             busy_o,
  output logic             inc_stage_o,
  output logic             load_stage_o
);

  seq_state_e state_q, state_d;
  logic       match;

  assign match = (opcode_i == OPCODE[OPC_W-1:0]);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i && match) state_d = ST_INTL;
      ST_INTL:  state_d = ST_STACK;
      ST_STACK: state_d = ST_LOAD;
      ST_LOAD:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign inc_stage_o  = (state_q == ST_STACK);
  assign load_stage_o = (state_q == ST_LOAD);

endmodule

// File: rtl/stat_pull_sp.sv
module stat_pull_sp #(
  parameter int              SP_W     = 16,
  parameter int              LOW_W    = 8,
  parameter logic [SP_W-1:0] SP_RST   = 16'h01FF,
  parameter logic [7:0]      EMU_PAGE = 8'h01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            emu_i,
  input  logic            inc_en_i,
  input  logic            wr_en_i,
  input  logic [SP_W-1:0] wr_data_i,
  output logic [SP_W-1:0] next_addr_o,
  output logic [SP_W-1:0] sp_view_o
);

  localparam int HIGH_W = SP_W - LOW_W;

  logic [SP_W-1:0]  sp_q, sp_d;
  logic [SP_W-1:0]  wide_step;
  logic [LOW_W-1:0] low_step;
  logic [SP_W-1:0]  page_step;
  logic [SP_W-1:0]  page_view;
  logic             sp_en;

  assign wide_step = sp_q + {{(SP_W-1){1'b0}}, 1'b1};
  assign low_step  = sp_q[LOW_W-1:0] + {{(LOW_W-1){1'b0}}, 1'b1};

  generate
    if (HIGH_W > 0) begin : g_paged
      assign page_step = {EMU_PAGE[HIGH_W-1:0], low_step};
      assign page_view = {EMU_PAGE[HIGH_W-1:0], sp_q[LOW_W-1:0]};
    end else begin : g_flat
      assign page_step = low_step;
      assign page_view = sp_q;
    end
  endgenerate

  assign next_addr_o = emu_i ? page_step : wide_step;

  always_comb begin
    sp_en = 1'b0;
    sp_d  = sp_q;
    if (inc_en_i) begin
      sp_en = 1'b1;
      sp_d  = next_addr_o;
    end else if (wr_en_i) begin
      sp_en = 1'b1;
      sp_d  = wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= SP_RST;
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp_view_o = emu_i ? page_view : sp_q;

endmodule

// File: rtl/stat_pull_psr.sv
module stat_pull_psr
  import stat_pull_pkg::*;
#(
  parameter int           P_W   = 8,
  parameter logic [P_W-1:0] P_RST = 8'h34,
  parameter logic         E_RST = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_en_i,
  input  logic [P_W-1:0] load_data_i,
  input  logic           wr_en_i,
  input  logic [P_W-1:0] wr_data_i,
  input  logic           e_wr_en_i,
  input  logic           e_wr_data_i,
  output logic [P_W-1:0] p_view_o,
  output logic           e_o,
  output logic           xh_clr_o
);

  logic [P_W-1:0] p_q, p_d, emu_form;
  logic           p_en;
  logic           e_q;

  generate
    for (genvar b = 0; b < P_W; b++) begin : g_bit
      if (b == FLAG_BIT_UNUSED) begin : g_fixed
        assign emu_form[b] = 1'b1;
      end else begin : g_pass
        assign emu_form[b] = load_data_i[b];
      end
    end
  endgenerate

  always_comb begin
    p_en = 1'b0;
    p_d  = p_q;
    if (load_en_i) begin
      p_en = 1'b1;
      p_d  = e_q ? emu_form : load_data_i;
    end else if (wr_en_i) begin
      p_en = 1'b1;
      p_d  = wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    p_q <= P_RST;
    else if (p_en) p_q <= p_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         e_q <= E_RST;
    else if (e_wr_en_i) e_q <= e_wr_data_i;
  end

  always_comb begin
    p_view_o = p_q;
    if (e_q) p_view_o[FLAG_BIT_UNUSED] = 1'b1;
  end

  assign e_o      = e_q;
  assign xh_clr_o = load_en_i & ~e_q & load_data_i[FLAG_BIT_INDEX];

endmodule

// File: rtl/stat_pull_seq.sv
module stat_pull_seq
  import stat_pull_pkg::*;
#(
  parameter int         SP_W  = 16,
  parameter int         P_W   = 8,
  parameter int         OPC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             sp_wr_en_i,
  input  logic [SP_W-1:0]  sp_wr_data_i,
  input  logic             p_wr_en_i,
  input  logic [P_W-1:0]   p_wr_data_i,
  input  logic             e_wr_en_i,
  input  logic             e_wr_data_i,
  output logic             mem_rd_en_o,
  output logic [SP_W-1:0]  mem_addr_o,
  input  logic [P_W-1:0]   mem_rd_data_i,
  output logic [SP_W-1:0]  sp_o,
  output logic [P_W-1:0]   p_o,
  output logic             e_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             xh_clr_o
);

  logic inc_stage, load_stage, emu;

  stat_pull_fsm #(.OPC_W(OPC_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .opcode_i     (opcode_i),
    .busy_o       (busy_o),
    .inc_stage_o  (inc_stage),
    .load_stage_o (load_stage)
  );

  stat_pull_sp #(.SP_W(SP_W)) u_sp (
    .clk         (clk),
    .rst_n       (rst_n),
    .emu_i       (emu),
    .inc_en_i    (inc_stage),
    .wr_en_i     (sp_wr_en_i),
    .wr_data_i   (sp_wr_data_i),
    .next_addr_o (mem_addr_o),
    .sp_view_o   (sp_o)
  );

  stat_pull_psr #(.P_W(P_W)) u_psr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en_i   (load_stage),
    .load_data_i (mem_rd_data_i),
    .wr_en_i     (p_wr_en_i),
    .wr_data_i   (p_wr_data_i),
    .e_wr_en_i   (e_wr_en_i),
    .e_wr_data_i (e_wr_data_i),
    .p_view_o    (p_o),
    .e_o         (emu),
    .xh_clr_o    (xh_clr_o)
  );

  assign e_o         = emu;
  assign mem_rd_en_o = inc_stage;
  assign done_o      = load_stage;

endmodule

// File: rtl/stat_pull_seq_chk.sv
module stat_pull_seq_chk #(
  parameter int SP_W = 16,
  parameter int P_W  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            e_wr_en_i,
  input logic            mem_rd_en_o,
  input logic [SP_W-1:0] mem_addr_o,
  input logic [SP_W-1:0] sp_o,
  input logic [P_W-1:0]  p_o,
  input logic            e_o,
  input logic            busy_o,
  input logic            done_o,
  input logic            xh_clr_o
);

  a_r3_read_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en_o |=> done_o);

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  a_r3_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en_o || done_o) |-> busy_o);

  a_r4_sp_follows_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en_o && !e_wr_en_i) |=> sp_o == $past(mem_addr_o));

  a_r5_page_one: assert property (@(posedge clk) disable iff (!rst_n)
    e_o |-> (sp_o[SP_W-1:8] == 8'h01) && (mem_addr_o[SP_W-1:8] == 8'h01));

  a_r8_bit5_set: assert property (@(posedge clk) disable iff (!rst_n)
    e_o |-> p_o[5]);

  a_r9_e_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !e_wr_en_i |=> $stable(e_o));

  a_r10_pulse_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    xh_clr_o |-> done_o && !e_o);

endmodule

bind stat_pull_seq stat_pull_seq_chk #(.SP_W(SP_W), .P_W(P_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .e_wr_en_i   (e_wr_en_i),
  .mem_rd_en_o (mem_rd_en_o),
  .mem_addr_o  (mem_addr_o),
  .sp_o        (sp_o),
  .p_o         (p_o),
  .e_o         (e_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .xh_clr_o    (xh_clr_o)
);

// File: tb/stat_pull_seq_bench.sv
module stat_pull_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  opcode_i = 8'h00;
  logic        sp_wr_en_i = 1'b0;
  logic [15:0] sp_wr_data_i = 16'h0000;
  logic        p_wr_en_i = 1'b0;
  logic [7:0]  p_wr_data_i = 8'h00;
  logic        e_wr_en_i = 1'b0;
  logic        e_wr_data_i = 1'b0;
  logic        mem_rd_en_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_rd_data_i = 8'h00;
  logic [15:0] sp_o;
  logic [7:0]  p_o;
  logic        e_o, busy_o, done_o, xh_clr_o;

  int   total = 0;
  int   bad = 0;
  bit   finished = 0;
  logic [7:0] salt = 8'h00;

  logic [15:0] m_sp;
  logic [7:0]  m_p;
  logic        m_e;

  always #4 clk = ~clk;

  stat_pull_seq u_stat_pull_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
    .sp_wr_en_i(sp_wr_en_i), .sp_wr_data_i(sp_wr_data_i),
    .p_wr_en_i(p_wr_en_i), .p_wr_data_i(p_wr_data_i),
    .e_wr_en_i(e_wr_en_i), .e_wr_data_i(e_wr_data_i),
    .mem_rd_en_o(mem_rd_en_o), .mem_addr_o(mem_addr_o),
    .mem_rd_data_i(mem_rd_data_i), .sp_o(sp_o), .p_o(p_o), .e_o(e_o),
    .busy_o(busy_o), .done_o(done_o), .xh_clr_o(xh_clr_o)
  );

  function automatic logic [7:0] mem_fn(logic [15:0] a, logic [7:0] s);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ s;
  endfunction

  always @(posedge clk) if (mem_rd_en_o) mem_rd_data_i <= mem_fn(mem_addr_o, salt);

  function automatic logic [15:0] sp_view(logic [15:0] sp, logic e);
    return e ? {8'h01, sp[7:0]} : sp;
  endfunction
  function automatic logic [15:0] sp_step(logic [15:0] sp, logic e);
    return e ? {8'h01, sp[7:0] + 8'h01} : sp + 16'h0001;
  endfunction
  function automatic logic [7:0] p_view(logic [7:0] p, logic e);
    return e ? (p | 8'h20) : p;
  endfunction
  function automatic logic [7:0] p_pulled(logic [7:0] d, logic e);
    return e ? (d | 8'h20) : d;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_sp(logic [15:0] v);
    @(negedge clk); sp_wr_en_i = 1'b1; sp_wr_data_i = v;
    @(negedge clk); sp_wr_en_i = 1'b0; m_sp = v;
  endtask
  task automatic wr_p(logic [7:0] v);
    @(negedge clk); p_wr_en_i = 1'b1; p_wr_data_i = v;
    @(negedge clk); p_wr_en_i = 1'b0; m_p = v;
  endtask
  task automatic wr_e(logic v);
    @(negedge clk); e_wr_en_i = 1'b1; e_wr_data_i = v;
    @(negedge clk); e_wr_en_i = 1'b0; m_e = v;
  endtask

  // one pull; optional colliding writes and a second strobe while busy
  task automatic run_pull(bit col_sp, bit col_p, bit restrobe);
    logic [15:0] a;
    logic [7:0]  d;
    a = sp_step(m_sp, m_e);
    d = mem_fn(a, salt);
    @(negedge clk); start_i = 1'b1; opcode_i = 8'h28;          // cycle 1
    @(negedge clk); start_i = restrobe; opcode_i = 8'h28;      // cycle 2
    check("R3 cycle2 busy/rd/done", {busy_o, mem_rd_en_o, done_o}, 3'b100);
    @(negedge clk); start_i = 1'b0;                            // cycle 3
    check("R3 cycle3 read", {busy_o, mem_rd_en_o, done_o}, 3'b110);
    check("R4 R5 R6 read address", mem_addr_o, a);
    if (col_sp) begin sp_wr_en_i = 1'b1; sp_wr_data_i = ~a; end
    @(negedge clk); sp_wr_en_i = 1'b0;                         // cycle 4
    check("R3 cycle4 done", {busy_o, mem_rd_en_o, done_o}, 3'b101);
    check("R4 R11 sp after step", sp_o, sp_view(a, m_e));
    check("R10 index clear", xh_clr_o, (!m_e && d[4]));
    if (col_p) begin p_wr_en_i = 1'b1; p_wr_data_i = ~d; end
    @(negedge clk); p_wr_en_i = 1'b0;                          // cycle 5
    m_sp = a;
    m_p  = p_pulled(d, m_e);
    check(m_e ? "R8 R11 emulation load" : "R7 R11 native load", p_o, p_view(m_p, m_e));
    check("R9 emulation flag kept", e_o, m_e);
    check("R2 R3 idle after pull", {busy_o, mem_rd_en_o, done_o, xh_clr_o}, 4'b0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    m_sp = 16'h01FF; m_p = 8'h34; m_e = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {busy_o, done_o, mem_rd_en_o, xh_clr_o}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sp after reset", sp_o, 16'h01FF);
    check("R1 p after reset", p_o, 8'h34);
    check("R1 e after reset", e_o, 1'b1);

    // R2: wrong opcode ignored
    @(negedge clk); start_i = 1'b1; opcode_i = 8'h08;
    @(negedge clk); start_i = 1'b0;
    repeat (3) begin
      check("R2 other opcode ignored", {busy_o, mem_rd_en_o, done_o}, 3'b000);
      @(negedge clk);
    end

    // R5: emulation wrap within page one
    salt = 8'h10;
    wr_sp(16'h37FF);
    check("R5 page view", sp_o, 16'h01FF);
    run_pull(0, 0, 1);
    check("R5 wrapped sp", sp_o, 16'h0100);

    // R6 and R10: native full wrap, X set
    wr_e(1'b0);
    wr_sp(16'hFFFF);
    check("R11 idle sp write lands", sp_o, 16'hFFFF);
    salt = 8'h10;   // data at 0x0000 = 0x10 -> X set, M clear
    run_pull(0, 0, 0);
    check("R6 native wrap", sp_o, 16'h0000);
    check("R7 exact byte", p_o, 8'h10);

    // R8: emulation, bit5 clear in data, bit4 set, no clear pulse
    wr_e(1'b1);
    wr_p(8'h00);
    check("R8 bit5 forced on write", p_o, 8'h20);
    salt = 8'h00;
    wr_sp(16'h0140);  // addr 0x0141 -> data 0x41^0x10 = 0x51
    run_pull(1, 1, 0);

    // R11 directed collisions in native
    wr_e(1'b0);
    run_pull(1, 1, 0);

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[0] != m_e) wr_e(r[0]);
      if (r[1]) wr_sp(r[2] ? {r[15:8], 8'hFF} : r[31:16]);
      if (r[3]) wr_p(r[11:4]);
      salt = r[23:16];
      if (r[5] && r[6]) begin
        @(negedge clk); start_i = 1'b1; opcode_i = r[31:24] == 8'h28 ? 8'h29 : r[31:24];
        @(negedge clk); start_i = 1'b0;
        check("R2 random opcode ignored", {busy_o, mem_rd_en_o}, 2'b00);
      end
      run_pull(r[12], r[13], r[14]);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule